// File: doc/BRIEF.md
# Two-Wire Command Slave Interface

This block is the serial front end of a small register-controlled peripheral. It watches a two-wire bus made of a clock line and a data line. Both lines pass through synchronizers clocked by the system clock. The block picks out start and stop conditions from the line transitions and then frames each transaction in a fixed order. The first byte is an address byte. In a write, a command byte follows it, and after that an optional data byte. The slave acknowledges every byte it accepts.

A completed command reaches the attached register block as a one-cycle strobe. The strobe carries the command code, the data byte, and a flag that tells whether a data byte came with it. In a read, the slave shifts a byte supplied by the register block onto the data line. The data line is open-drain: the block either pulls it low or releases it.

Four strap inputs form part of the address that is matched. A protect input stops any command that carries data from reaching the register block.

Top module: `twc_slave`

## Requirements
- R1: `sda_pull_o` (1 = pull the data line low, 0 = release it) changes only while the synchronized clock line is low.
- R2: Until a start condition (data falling while the clock is high) has been seen, the block acknowledges nothing and issues no strobe. A stop condition (data rising while the clock is high) ends any transaction.
- R3: Bits are sampled on clock rising edges, MSB first. For each byte the slave accepts, it pulls the data line low through the ninth clock pulse.
- R4: An address byte matches when bits [7:5] equal `DEV_TYPE` (default 3'b101) and bits [4:1] equal `strap_i`. Bit [0] selects the direction: 0 = write, 1 = read. A matching address byte is acknowledged.
- R5: A non-matching address byte gets no acknowledge. The slave then acknowledges nothing and strobes nothing until the next start.
- R6: A write transaction that ends with a stop or start right after the command byte produces one strobe at that condition, with `cmd_wr_o` = 0 and `cmd_code_o` = the command byte.
- R7: If a data byte follows the command byte, the strobe is issued at the end of that byte's eighth bit, with `cmd_wr_o` = 1 and `cmd_data_o` = the data byte. Any further bytes are not acknowledged.
- R8: When `wprot_i` is high at the end of a data byte, that byte is still acknowledged but no strobe is issued. A command without data still strobes.
- R9: In a read, `rd_byte_i` is captured at the end of the address byte. It is shifted out MSB first, one bit per clock low phase, starting right after the address acknowledge. The line is released for the master's ninth-clock response.
- R10: A start in the middle of a transaction restarts framing at a new address byte. A command that was pending without data is strobed at that start.
- R11: During and after reset, the data line is released and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | STRAP_W | Strap address bits matched against address bits [4:1] |
| wprot_i | input | 1 | Write protect: suppresses strobes of commands carrying data |
| rd_byte_i | input | 8 | Byte returned to the master in a read |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 8 | Command byte of the strobed command |
| cmd_data_o | output | 8 | Data byte of the strobed command |
| cmd_wr_o | output | 1 | 1 when the strobed command carried a data byte |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a transaction while a command is still waiting to learn whether data will follow. A strobe must leave at exactly that boundary, and framing must fall back to an address byte. The bench drives the master side as a bit-level model. It issues a command byte with no data and then a fresh start instead of a stop. It then checks that the pending strobe appears before the second address byte is judged, and that the second write is framed and strobed on its own. A second hard case is the read direction. There the slave, not the master, must change the line in each clock low phase; the bench samples each bit late in the clock high phase and watches every change of the pull output against the clock line.

// File: rtl/twc_pkg.sv
`timescale 1ns/1ps
package twc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_WAIT
    } twc_state_e;

    typedef struct packed {
        twc_state_e         state;
        logic [CNT_W-1:0]   bitcnt;
        logic               acking;
        logic               drive;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  tx;
        logic [BYTE_W-1:0]  cmd;
        logic               have_cmd;
        logic               stb;
        logic [BYTE_W-1:0]  stb_code;
        logic [BYTE_W-1:0]  stb_data;
        logic               stb_wr;
    } twc_frame_t;
endpackage

// File: rtl/twc_sync.sv
`timescale 1ns/1ps
module twc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    // bits [STAGES-1:0]: synchronizer chain, bit STAGES: previous synced value
    localparam int W = STAGES + 1;

    logic [W-1:0] scl_d, scl_q, sda_d, sda_q;
    logic scl_prev, sda_prev;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_lvl   = scl_q[STAGES-1];
    assign sda_lvl   = sda_q[STAGES-1];
    assign scl_prev  = scl_q[STAGES];
    assign sda_prev  = sda_q[STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twc_frame.sv
`timescale 1ns/1ps
module twc_frame
    import twc_pkg::*;
#(
    parameter int                    DEV_TYPE_W = 3,
    parameter int                    STRAP_W    = 4,
    parameter logic [DEV_TYPE_W-1:0] DEV_TYPE   = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wprot,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               drive_low,
    output logic               stb,
    output logic [BYTE_W-1:0]  stb_code,
    output logic [BYTE_W-1:0]  stb_data,
    output logic               stb_wr
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    twc_frame_t d, q;
    logic       addr_match;

    assign addr_match = (q.shreg[BYTE_W-1 -: DEV_TYPE_W] == DEV_TYPE) &&
                        (q.shreg[STRAP_W:1] == strap);

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (bus_start || bus_stop) begin
            if (q.have_cmd) begin
                d.stb      = 1'b1;
                d.stb_code = q.cmd;
                d.stb_data = '0;
                d.stb_wr   = 1'b0;
            end
            d.have_cmd = 1'b0;
            d.bitcnt   = '0;
            d.acking   = 1'b0;
            d.drive    = 1'b0;
            d.state    = bus_start ? ST_ADDR : ST_IDLE;
        end else if (q.state == ST_IDLE) begin
            d.drive = 1'b0;
        end else if (q.acking) begin
            if (scl_fall) begin
                d.acking = 1'b0;
                d.bitcnt = '0;
                d.drive  = (q.state == ST_READ) ? ~q.tx[BYTE_W-1] : 1'b0;
            end
        end else if (q.state == ST_READ) begin
            if (scl_rise && q.bitcnt < FULL) begin
                d.bitcnt = q.bitcnt + 1'b1;
            end else if (scl_fall) begin
                if (q.bitcnt == FULL) begin
                    d.drive = 1'b0;
                    d.state = ST_WAIT;
                end else begin
                    d.tx    = q.tx << 1;
                    d.drive = ~q.tx[BYTE_W-2];
                end
            end
        end else if (q.state != ST_WAIT) begin
            if (scl_rise && q.bitcnt < FULL) begin
                d.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl};
                d.bitcnt = q.bitcnt + 1'b1;
            end else if (scl_fall && q.bitcnt == FULL) begin
                d.acking = 1'b1;
                d.drive  = 1'b1;
                case (q.state)
                    ST_ADDR: begin
                        if (addr_match) begin
                            d.state = q.shreg[0] ? ST_READ : ST_CMD;
                            d.tx    = rd_byte;
                        end else begin
                            d.acking = 1'b0;
                            d.drive  = 1'b0;
                            d.state  = ST_WAIT;
                        end
                    end
                    ST_CMD: begin
                        d.cmd      = q.shreg;
                        d.have_cmd = 1'b1;
                        d.state    = ST_DATA;
                    end
                    default: begin
                        d.have_cmd = 1'b0;
                        d.state    = ST_WAIT;
                        if (!wprot) begin
                            d.stb      = 1'b1;
                            d.stb_code = q.cmd;
                            d.stb_data = q.shreg;
                            d.stb_wr   = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign drive_low = q.drive;
    assign stb       = q.stb;
    assign stb_code  = q.stb_code;
    assign stb_data  = q.stb_data;
    assign stb_wr    = q.stb_wr;

    // R1: the data line is only touched while the clock line is low
    a_r1_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.drive) |-> !scl_lvl);

    // R3: an acknowledge phase begins only after eight bits were taken
    a_r3_ack_after_eight: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.acking) |-> $past(q.bitcnt) == FULL);

    // R5: while ignoring traffic the line stays released
    a_r5_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !q.acking) |-> !q.drive);

    // R8: no data-carrying strobe while protect was high
    a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stb && q.stb_wr) |-> !$past(wprot));

    // R11: outside a transaction the line is released
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !q.drive);
endmodule

// File: rtl/twc_slave.sv
`timescale 1ns/1ps
module twc_slave
    import twc_pkg::*;
#(
    parameter int                    SYNC_STAGES = 2,
    parameter int                    DEV_TYPE_W  = 3,
    parameter int                    STRAP_W     = 4,
    parameter logic [DEV_TYPE_W-1:0] DEV_TYPE    = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wprot_i,
    input  logic [BYTE_W-1:0]  rd_byte_i,
    output logic               cmd_stb_o,
    output logic [BYTE_W-1:0]  cmd_code_o,
    output logic [BYTE_W-1:0]  cmd_data_o,
    output logic               cmd_wr_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

    twc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    twc_frame #(
        .DEV_TYPE_W (DEV_TYPE_W),
        .STRAP_W    (STRAP_W),
        .DEV_TYPE   (DEV_TYPE)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .strap     (strap_i),
        .wprot     (wprot_i),
        .rd_byte   (rd_byte_i),
        .drive_low (sda_pull_o),
        .stb       (cmd_stb_o),
        .stb_code  (cmd_code_o),
        .stb_data  (cmd_data_o),
        .stb_wr    (cmd_wr_o)
    );
endmodule

// File: tb/twc_slave_test.sv
`timescale 1ns/1ps
module twc_slave_test;
    localparam int P = 10;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] cmd;
        logic [7:0] data;
        logic       hd;
        logic       wp;
        logic       ack;
        logic       stb;
        logic       wr;
    } vec_t;

    // strap 4'b0110, type 3'b101: write address 8'hAC, read address 8'hAD
    localparam vec_t VEC [6] = '{
        '{8'hAC, 8'h3C, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{8'hAC, 8'h81, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'hAC, 8'h7E, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'hAC, 8'h12, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'hAE, 8'h44, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h8C, 8'h44, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'b0110;
    logic       wprot = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       pull, stb, wr;
    logic [7:0] code, data;
    logic       sda_line;

    assign sda_line = sda_m & ~pull;

    twc_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .strap_i    (strap),
        .wprot_i    (wprot),
        .rd_byte_i  (rd_byte),
        .cmd_stb_o  (stb),
        .cmd_code_o (code),
        .cmd_data_o (data),
        .cmd_wr_o   (wr)
    );

    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    int r1_bad = 0;
    logic [7:0] last_code = 8'h00;
    logic [7:0] last_data = 8'h00;
    logic       last_wr = 1'b0;
    logic       prev_pull = 1'b0;
    bit         done = 1'b0;

    always @(negedge clk) begin
        if (stb) begin
            stb_cnt++;
            last_code = code;
            last_data = data;
            last_wr   = wr;
        end
        if (pull != prev_pull && scl_m) r1_bad++;
        prev_pull = pull;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(P);
        scl_m = 1'b1; idle(P);
        sda_m = 1'b0; idle(P);
        scl_m = 1'b0; idle(P);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(P);
        scl_m = 1'b1; idle(P);
        sda_m = 1'b1; idle(P);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; idle(P);
            scl_m = 1'b1; idle(P);
            scl_m = 1'b0; idle(P);
        end
        sda_m = 1'b1; idle(P);
        scl_m = 1'b1; idle(P);
        ack = ~sda_line;
        scl_m = 1'b0; idle(P);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; idle(P);
            b[i] = sda_line;
            scl_m = 1'b0; idle(P);
        end
        sda_m = ~mack; idle(P);
        scl_m = 1'b1; idle(P);
        scl_m = 1'b0; idle(P);
        sda_m = 1'b1; idle(P);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] rb;
        int         base;

        idle(5);
        check("R11 pull in reset", int'(pull), 0);
        check("R11 strobe in reset", stb_cnt, 0);
        rst_n = 1'b1;
        idle(5);
        check("R11 pull after reset", int'(pull), 0);

        // R2: a matching byte clocked without a start is ignored
        send_byte(8'hAC, a);
        check("R2 no ack before start", int'(a), 0);
        bus_stop();
        idle(P);
        check("R2 no strobe before start", stb_cnt, 0);

        foreach (VEC[k]) begin
            wprot = VEC[k].wp;
            base  = stb_cnt;
            bus_start();
            send_byte(VEC[k].addr, a);
            check(VEC[k].ack ? "R4 address ack" : "R5 address nack", int'(a), int'(VEC[k].ack));
            send_byte(VEC[k].cmd, a);
            check("R3 command ack", int'(a), int'(VEC[k].ack));
            if (VEC[k].hd) begin
                send_byte(VEC[k].data, a);
                check("R3 data ack", int'(a), int'(VEC[k].ack));
            end
            bus_stop();
            idle(P);
            check(VEC[k].wp ? "R8 strobe count" : (VEC[k].hd ? "R7 strobe count" : "R6 strobe count"),
                  stb_cnt - base, int'(VEC[k].stb));
            if (VEC[k].stb) begin
                check("R6 strobe code", int'(last_code), int'(VEC[k].cmd));
                check("R7 strobe write flag", int'(last_wr), int'(VEC[k].wr));
                if (VEC[k].wr) check("R7 strobe data", int'(last_data), int'(VEC[k].data));
            end
        end
        wprot = 1'b0;

        // R9: read returns the supplied byte
        rd_byte = 8'hC5;
        base = stb_cnt;
        bus_start();
        send_byte(8'hAD, a);
        check("R9 read address ack", int'(a), 1);
        rd_byte = 8'h00;
        read_byte(rb, 1'b0);
        check("R9 read byte", int'(rb), 'hC5);
        bus_stop();
        idle(P);
        check("R9 line released after read", int'(pull), 0);
        check("R9 no strobe on read", stb_cnt - base, 0);

        // R7: bytes after the data byte are refused
        base = stb_cnt;
        bus_start();
        send_byte(8'hAC, a);
        send_byte(8'h21, a);
        send_byte(8'h99, a);
        send_byte(8'h77, a);
        check("R7 extra byte nack", int'(a), 0);
        bus_stop();
        idle(P);
        check("R7 one strobe", stb_cnt - base, 1);
        check("R7 first data kept", int'(last_data), 'h99);

        // R10: repeated start after a command with no data
        base = stb_cnt;
        bus_start();
        send_byte(8'hAC, a);
        send_byte(8'h55, a);
        bus_start();
        check("R10 pending strobe at restart", stb_cnt - base, 1);
        check("R10 pending code", int'(last_code), 'h55);
        check("R10 pending write flag", int'(last_wr), 0);
        send_byte(8'hAC, a);
        check("R10 new address ack", int'(a), 1);
        send_byte(8'h66, a);
        send_byte(8'h11, a);
        check("R10 data ack after restart", int'(a), 1);
        bus_stop();
        idle(P);
        check("R10 second strobe", stb_cnt - base, 2);
        check("R10 second code", int'(last_code), 'h66);
        check("R10 second data", int'(last_data), 'h11);

        check("R1 pull changed with clock high", r1_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule